// File: doc/BRIEF.md
# Multi-mode programmable counter channel

This block is one down-counting channel of a programmable interval timer. An initial count is loaded with a strobe, together with a mode code and a binary/BCD select. The channel then counts down on single-cycle count-enable ticks and drives an output pin. The pin's behaviour depends on the mode, and there are six modes. A gate input either pauses counting or retriggers it, depending on the mode. The count, the pin level and a flag that marks a written but not yet transferred count are all available for a status path outside the block.

Four modes are non-periodic and keep counting through zero. The other two reload themselves on every expiry. One of the periodic modes produces a short pulse at the end of each period, and the other produces a square wave. An initial count of zero stands for the largest count in either number system. In BCD, a borrow is carried digit by digit.

Top module: `ivl_counter_chan`

## Requirements
- R1: After reset, count_o is 0, out_o is low and null_o is low.
- R2: A load strobe captures the count, the mode and the BCD select. At the following edge null_o is high and count_o is unchanged. out_o goes low in mode 0 and high in every other mode. A tick in the same cycle as a load is ignored.
- R3: In modes 0, 2, 3 and 4, the first tick after a load copies the initial count into the counter and clears null_o. In modes 1 and 5, the copy waits for a gate rising edge and happens on the first tick after the cycle of that edge.
- R4: In modes 0 and 4, a tick counts only while the gate is high. In modes 1 and 5 the gate level is ignored. In modes 2 and 3, a tick with the gate low holds the count and forces out_o high. A gate rising edge in modes 2 and 3 reloads the initial count on the next tick after the edge cycle; a tick in the edge cycle itself still counts.
- R5: In modes 0, 1, 4 and 5 the counter keeps counting past zero, to FFFF in binary or 9999 in BCD.
- R6: In mode 0, out_o rises on the tick that takes the count from 1 to 0. It stays high until the next load.
- R7: In mode 1, out_o goes low on the triggered transfer and rises when the count reaches 0. A new gate edge restarts the count.
- R8: In modes 4 and 5, out_o is low for exactly one tick period after the count reaches 0, and then returns high.
- R9: Mode 2 has a period of N ticks, where N is the initial count. out_o is low only during the last tick period of each period, and the count reloads to N at the end of the period.
- R10: In mode 3, out_o is high for the first (N+1)/2 tick periods of each N-tick period and low for the rest. The count steps down by one per tick and reloads to N at the end of the period.
- R11: Mode codes 6 and 7 behave exactly as modes 2 and 3.
- R12: An initial count of 0 behaves as 65536 ticks in binary and as 10000 ticks in BCD.
- R13: In BCD, each 4-bit digit decrements from 0 to 9 with a borrow into the next digit, so 0010 becomes 0009 and 1000 becomes 0999.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count enable, one clock wide per count step |
| gate_i | input | 1 | Gate level, synchronous to clk |
| load_i | input | 1 | Load strobe for a new count and mode |
| load_val_i | input | CNT_W | Initial count (binary, or BCD digits) |
| mode_i | input | 3 | Mode code 0 to 7 |
| bcd_i | input | 1 | 1 selects BCD counting |
| count_o | output | CNT_W | Current count |
| out_o | output | 1 | Output pin level |
| null_o | output | 1 | High from a load until the count is transferred |

## Verification
A load strobe and a count tick can land in the same cycle. A gate rising edge and a count tick can also coincide. The bench drives both cases on purpose. For the load-plus-tick case, it checks that the count holds for that cycle and that the transfer follows on the next tick. For the gate case, it uses mode 2 and checks two things: the coincident tick still decrements the count and produces the end-of-period pulse, and the reload happens only on the tick after the edge.

// File: rtl/ivl_pkg.sv
package ivl_pkg;
  typedef enum logic [2:0] {
    M_TERM    = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } ivl_mode_e;

  // codes 6 and 7 alias the two periodic modes
  function automatic ivl_mode_e fold_mode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return ivl_mode_e'({1'b0, code[1:0]});
    return ivl_mode_e'(code);
  endfunction
endpackage

// File: rtl/ivl_dec.sv
module ivl_dec #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] val_i,
  input  logic             bcd_i,
  output logic [CNT_W-1:0] dec_o
);
  localparam int DIG = CNT_W / 4;

  logic [DIG-1:0]   brw;   // borrow into digit d
  logic [CNT_W-1:0] bcd_res;

  assign brw[0] = 1'b1;

  for (genvar d = 0; d < DIG; d++) begin : g_dig
    logic [3:0] nib;
    assign nib = val_i[4*d +: 4];
    assign bcd_res[4*d +: 4] = !brw[d] ? nib :
                               ((nib == 4'd0) ? 4'd9 : nib - 4'd1);
    if (d < DIG-1) begin : g_chain
      assign brw[d+1] = brw[d] & (nib == 4'd0);
    end
  end

  assign dec_o = bcd_i ? bcd_res : (val_i - CNT_W'(1));
endmodule

// File: rtl/ivl_len.sv
module ivl_len #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] init_i,
  input  logic             bcd_i,
  output logic [CNT_W:0]   len_o
);
  localparam int DIG   = CNT_W / 4;
  localparam int LEN_W = CNT_W + 1;

  function automatic logic [CNT_W:0] dec_span();
    logic [CNT_W:0] p;
    p = LEN_W'(1);
    for (int i = 0; i < DIG; i++) p = (p << 3) + (p << 1);
    return p;
  endfunction

  localparam logic [CNT_W:0] BCD_SPAN = dec_span();
  localparam logic [CNT_W:0] BIN_SPAN = {1'b1, {CNT_W{1'b0}}};

  logic [CNT_W:0] acc;

  always_comb begin
    acc = '0;
    for (int d = DIG-1; d >= 0; d--)
      acc = (acc << 3) + (acc << 1) + LEN_W'(init_i[4*d +: 4]);
  end

  always_comb begin
    if (bcd_i) len_o = (acc == '0) ? BCD_SPAN : acc;
    else       len_o = (init_i == '0) ? BIN_SPAN : {1'b0, init_i};
  end
endmodule

// File: rtl/ivl_phase.sv
module ivl_phase #(
  parameter int CNT_W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr_i,
  input  logic           adv_i,
  input  logic [CNT_W:0] len_i,
  output logic [CNT_W:0] ph_nxt_o,
  output logic           wrap_o
);
  localparam int LEN_W = CNT_W + 1;

  logic [CNT_W:0] ph_q;

  assign wrap_o = (ph_q == len_i - LEN_W'(1));

  always_comb begin
    if (clr_i)      ph_nxt_o = '0;
    else if (adv_i) ph_nxt_o = wrap_o ? '0 : ph_q + LEN_W'(1);
    else            ph_nxt_o = ph_q;
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= ph_nxt_o;
  end
endmodule

// File: rtl/ivl_counter_chan.sv
module ivl_counter_chan
  import ivl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [2:0]       mode_i,
  input  logic             bcd_i,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o,
  output logic             null_o
);
  localparam int LEN_W = CNT_W + 1;
  localparam int DIG   = CNT_W / 4;

  ivl_mode_e        mode_q, mode_in;
  logic             bcd_q;
  logic [CNT_W-1:0] init_q, cnt_q, cnt_dec;
  logic [LEN_W-1:0] len_q, len_in, ph_nxt, half;
  logic             pend_q, trig_q, run_q, armed_q, out_q, null_q, gate_q;
  logic             rise, is_trig, is_per, is_strobe, gate_ok;
  logic             xfer, step, expire, wrap, per_out;

  assign mode_in   = fold_mode(mode_i);
  assign rise      = gate_i & ~gate_q;
  assign is_trig   = (mode_q == M_ONESHOT) || (mode_q == M_HWSTB);
  assign is_per    = (mode_q == M_RATE)    || (mode_q == M_SQUARE);
  assign is_strobe = (mode_q == M_SWSTB)   || (mode_q == M_HWSTB);
  assign gate_ok   = is_trig | gate_i;

  // transfer of the initial count into the counter
  assign xfer = tick_i & ~load_i &
                ((pend_q & ~is_trig) |
                 (trig_q & (is_trig | is_per) & (pend_q | run_q)));
  assign step   = tick_i & ~load_i & run_q & ~xfer & gate_ok;
  assign expire = step & ~is_per & (cnt_q == CNT_W'(1));

  ivl_dec #(.CNT_W(CNT_W)) u_dec (
    .val_i (cnt_q),
    .bcd_i (bcd_q),
    .dec_o (cnt_dec)
  );

  ivl_len #(.CNT_W(CNT_W)) u_len (
    .init_i (load_val_i),
    .bcd_i  (bcd_i),
    .len_o  (len_in)
  );

  ivl_phase #(.CNT_W(CNT_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (xfer),
    .adv_i    (step & is_per),
    .len_i    (len_q),
    .ph_nxt_o (ph_nxt),
    .wrap_o   (wrap)
  );

  assign half    = (len_q + LEN_W'(1)) >> 1;
  assign per_out = (mode_q == M_SQUARE) ? (ph_nxt < half)
                                        : (ph_nxt != len_q - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= M_TERM;
      bcd_q   <= 1'b0;
      init_q  <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      trig_q  <= 1'b0;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      out_q   <= 1'b0;
      null_q  <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      gate_q <= gate_i;
      if (load_i) begin
        mode_q  <= mode_in;
        bcd_q   <= bcd_i;
        init_q  <= load_val_i;
        len_q   <= len_in;
        pend_q  <= 1'b1;
        null_q  <= 1'b1;
        run_q   <= 1'b0;
        trig_q  <= 1'b0;
        armed_q <= 1'b0;
        out_q   <= (mode_in != M_TERM);
      end else begin
        trig_q <= (trig_q & ~tick_i) | rise;
        if (xfer) begin
          cnt_q   <= init_q;
          pend_q  <= 1'b0;
          null_q  <= 1'b0;
          run_q   <= 1'b1;
          armed_q <= 1'b1;
          case (mode_q)
            M_TERM, M_ONESHOT: out_q <= 1'b0;
            M_RATE, M_SQUARE:  out_q <= per_out;
            default:           out_q <= 1'b1;
          endcase
        end else if (step) begin
          if (is_per) begin
            cnt_q <= wrap ? init_q : cnt_dec;
            out_q <= per_out;
          end else begin
            cnt_q <= cnt_dec;
            if (is_strobe) begin
              out_q <= ~(expire & armed_q);
              if (expire) armed_q <= 1'b0;
            end else if (expire) begin
              out_q <= 1'b1;
            end
          end
        end else if (tick_i & (is_per | is_strobe)) begin
          out_q <= 1'b1;
        end
      end
    end
  end

  assign count_o = cnt_q;
  assign out_o   = out_q;
  assign null_o  = null_q;

  function automatic logic digits_ok(input logic [CNT_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < DIG; d++) if (v[4*d +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // R2: a load always raises the null flag and freezes the count
  a_r2_null_after_load: assert property (@(posedge clk) disable iff (rst)
    load_i |=> null_o);
  a_r2_load_holds_count: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == $past(cnt_q)));
  // R5: binary wrap from zero to all ones
  a_r5_bin_wrap: assert property (@(posedge clk) disable iff (rst)
    (step && !is_per && !bcd_q && cnt_q == '0) |=> (cnt_q == '1));
  // R6: terminal-count output stays high until a load
  a_r6_term_sticky: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_TERM && out_q && !load_i) |=> out_q);
  // R8: strobe lasts one tick period
  a_r8_strobe_one_tick: assert property (@(posedge clk) disable iff (rst)
    (is_strobe && run_q && !out_q && tick_i && !load_i) |=> out_q);
  // R9: periodic modes reload the initial count at end of period
  a_r9_period_reload: assert property (@(posedge clk) disable iff (rst)
    (is_per && step && wrap) |=> (cnt_q == $past(init_q)));
  // R13: BCD counting keeps every digit in 0..9
  a_r13_bcd_digits: assert property (@(posedge clk) disable iff (rst)
    (bcd_q && !load_i && digits_ok(cnt_q) && digits_ok(init_q))
      |=> digits_ok(cnt_q));
endmodule

// File: tb/ivl_counter_chan_tb_top.sv
module ivl_counter_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, gate = 1'b0, load = 1'b0, bcd = 1'b0;
  logic [15:0] load_val = '0;
  logic [2:0]  mode = '0;
  logic [15:0] cnt_w;
  logic        out_w, null_w;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [15:0] c;
    logic        o;
    logic        n;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t mon_e;

  always #10 clk = ~clk;

  ivl_counter_chan #(.CNT_W(16)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick),
    .gate_i     (gate),
    .load_i     (load),
    .load_val_i (load_val),
    .mode_i     (mode),
    .bcd_i      (bcd),
    .count_o    (cnt_w),
    .out_o      (out_w),
    .null_o     (null_w)
  );

  // monitor: compares the state produced by the edge just past
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      mon_e = q.pop_front();
      checks++;
      if (cnt_w !== mon_e.c || out_w !== mon_e.o || null_w !== mon_e.n) begin
        errors++;
        $display("FAIL %s: count=%h out=%b null=%b, expected count=%h out=%b null=%b",
                 mon_e.tag, cnt_w, out_w, null_w, mon_e.c, mon_e.o, mon_e.n);
      end
    end
  end

  task automatic go(input logic en);
    @(negedge clk);
    tick = en;
    load = 1'b0;
  endtask

  task automatic ld(input logic [15:0] v, input logic [2:0] m, input logic b);
    load = 1'b1; load_val = v; mode = m; bcd = b;
  endtask

  task automatic exp_st(input logic [15:0] c, input logic o, input logic n,
                        input string tag);
    exp_t e;
    e.c = c; e.o = o; e.n = n; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) go(1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    exp_st(16'h0, 1'b0, 1'b0, "R1 reset state");
    @(negedge clk); rst = 1'b0;

    // mode 0, binary
    gate = 1'b1;
    go(0); ld(16'd3, 3'd0, 1'b0); exp_st(16'h0, 0, 1, "R2 mode0 load");
    go(1); exp_st(16'd3, 0, 0, "R3 transfer on tick");
    go(1); exp_st(16'd2, 0, 0, "R6 counting");
    go(1); exp_st(16'd1, 0, 0, "R6 before expiry");
    go(1); exp_st(16'd0, 1, 0, "R6 out rises at zero");
    go(1); exp_st(16'hFFFF, 1, 0, "R5 binary wrap");
    go(1); gate = 1'b0; exp_st(16'hFFFF, 1, 0, "R4 gate low pauses mode0");
    go(1); gate = 1'b1; exp_st(16'hFFFE, 1, 0, "R6 out stays high");
    go(1); ld(16'd5, 3'd0, 1'b0); exp_st(16'hFFFE, 0, 1, "R2 load wins over tick");
    go(1); exp_st(16'd5, 0, 0, "R3 transfer after load+tick");

    // mode 4
    go(0); ld(16'd2, 3'd4, 1'b0); exp_st(16'd5, 1, 1, "R2 mode4 load");
    go(1); exp_st(16'd2, 1, 0, "R3 mode4 transfer");
    go(1); exp_st(16'd1, 1, 0, "R8 before expiry");
    go(1); exp_st(16'd0, 0, 0, "R8 strobe low");
    go(1); exp_st(16'hFFFF, 1, 0, "R8 strobe one tick");

    // mode 2
    go(0); ld(16'd3, 3'd2, 1'b0); exp_st(16'hFFFF, 1, 1, "R2 mode2 load");
    go(1); exp_st(16'd3, 1, 0, "R3 mode2 transfer");
    go(1); exp_st(16'd2, 1, 0, "R9 first period");
    go(1); exp_st(16'd1, 0, 0, "R9 pulse at period end");
    go(1); exp_st(16'd3, 1, 0, "R9 reload");
    go(1); exp_st(16'd2, 1, 0, "R9 second period");
    go(1); exp_st(16'd1, 0, 0, "R9 second pulse");
    go(1); gate = 1'b0; exp_st(16'd1, 1, 0, "R4 gate low holds, out high");
    go(0); gate = 1'b1; exp_st(16'd1, 1, 0, "R4 edge cycle alone");
    go(1); exp_st(16'd3, 1, 0, "R4 rising edge reloads");
    go(1); exp_st(16'd2, 1, 0, "R9 after retrigger");
    go(0); gate = 1'b0;
    go(1); gate = 1'b1; exp_st(16'd1, 0, 0, "R4 tick with edge still counts");
    go(1); exp_st(16'd3, 1, 0, "R4 edge reloads on next tick");

    // code 6
    go(0); ld(16'd2, 3'd6, 1'b0); exp_st(16'd3, 1, 1, "R11 code6 load");
    go(1); exp_st(16'd2, 1, 0, "R11 code6 transfer");
    go(1); exp_st(16'd1, 0, 0, "R11 code6 pulse");
    go(1); exp_st(16'd2, 1, 0, "R11 code6 reload");

    // mode 3, odd count
    go(0); ld(16'd5, 3'd3, 1'b0); exp_st(16'd2, 1, 1, "R2 mode3 load");
    go(1); exp_st(16'd5, 1, 0, "R10 high 1");
    go(1); exp_st(16'd4, 1, 0, "R10 high 2");
    go(1); exp_st(16'd3, 1, 0, "R10 high 3");
    go(1); exp_st(16'd2, 0, 0, "R10 low 1");
    go(1); exp_st(16'd1, 0, 0, "R10 low 2");
    go(1); exp_st(16'd5, 1, 0, "R10 reload");

    // code 7, even count
    go(0); ld(16'd4, 3'd7, 1'b0); exp_st(16'd5, 1, 1, "R11 code7 load");
    go(1); exp_st(16'd4, 1, 0, "R11 code7 high 1");
    go(1); exp_st(16'd3, 1, 0, "R11 code7 high 2");
    go(1); exp_st(16'd2, 0, 0, "R11 code7 low 1");
    go(1); exp_st(16'd1, 0, 0, "R11 code7 low 2");
    go(1); exp_st(16'd4, 1, 0, "R11 code7 reload");

    // mode 1
    go(0); gate = 1'b0; ld(16'd2, 3'd1, 1'b0); exp_st(16'd4, 1, 1, "R2 mode1 load");
    go(1); exp_st(16'd4, 1, 1, "R3 mode1 waits for trigger");
    go(0); gate = 1'b1; exp_st(16'd4, 1, 1, "R3 trigger edge cycle");
    go(1); exp_st(16'd2, 0, 0, "R7 triggered start");
    go(1); exp_st(16'd1, 0, 0, "R7 counting");
    go(1); exp_st(16'd0, 1, 0, "R7 out high at zero");
    go(1); gate = 1'b0; exp_st(16'hFFFF, 1, 0, "R4 mode1 ignores gate level, R5 wrap");
    go(0); gate = 1'b1; exp_st(16'hFFFF, 1, 0, "R7 retrigger edge");
    go(1); exp_st(16'd2, 0, 0, "R7 retrigger restarts");

    // mode 5
    go(0); gate = 1'b0; ld(16'd2, 3'd5, 1'b0); exp_st(16'd2, 1, 1, "R2 mode5 load");
    go(0); gate = 1'b1; exp_st(16'd2, 1, 1, "R3 mode5 edge");
    go(1); exp_st(16'd2, 1, 0, "R3 mode5 triggered transfer");
    go(1); exp_st(16'd1, 1, 0, "R8 mode5 counting");
    go(1); exp_st(16'd0, 0, 0, "R8 mode5 strobe");
    go(1); exp_st(16'hFFFF, 1, 0, "R8 mode5 strobe ends");

    // BCD
    go(0); ld(16'h0012, 3'd0, 1'b1); exp_st(16'hFFFF, 0, 1, "R2 bcd load");
    go(1); exp_st(16'h0012, 0, 0, "R3 bcd transfer");
    go(1); exp_st(16'h0011, 0, 0, "R13 decrement");
    go(1); exp_st(16'h0010, 0, 0, "R13 decrement");
    go(1); exp_st(16'h0009, 0, 0, "R13 borrow across digit");
    go(0); ld(16'h0001, 3'd0, 1'b1); exp_st(16'h0009, 0, 1, "R2 bcd load");
    go(1); exp_st(16'h0001, 0, 0, "R3 bcd transfer");
    go(1); exp_st(16'h0000, 1, 0, "R6 bcd expiry");
    go(1); exp_st(16'h9999, 1, 0, "R5 bcd wrap");
    go(0); ld(16'h1000, 3'd0, 1'b1); exp_st(16'h9999, 0, 1, "R2 bcd load");
    go(1); exp_st(16'h1000, 0, 0, "R3 bcd transfer");
    go(1); exp_st(16'h0999, 0, 0, "R13 multi-digit borrow");

    // BCD mode 3, period ten
    go(0); ld(16'h0010, 3'd3, 1'b1); exp_st(16'h0999, 1, 1, "R2 bcd mode3 load");
    go(1); exp_st(16'h0010, 1, 0, "R10 bcd high");
    go(1); exp_st(16'h0009, 1, 0, "R10 bcd high");
    go(1); exp_st(16'h0008, 1, 0, "R10 bcd high");
    go(1); exp_st(16'h0007, 1, 0, "R10 bcd high");
    go(1); exp_st(16'h0006, 1, 0, "R10 bcd last high");
    go(1); exp_st(16'h0005, 0, 0, "R10 bcd first low");
    run(3);
    go(1); exp_st(16'h0001, 0, 0, "R10 bcd last low");
    go(1); exp_st(16'h0010, 1, 0, "R10 bcd reload");

    // zero count, binary
    go(0); ld(16'h0000, 3'd0, 1'b0); exp_st(16'h0010, 0, 1, "R2 zero load");
    go(1); exp_st(16'h0000, 0, 0, "R12 zero transfer");
    run(65534);
    go(1); exp_st(16'h0001, 0, 0, "R12 no early expiry");
    go(1); exp_st(16'h0000, 1, 0, "R12 expiry after 65536 ticks");

    // zero count, BCD mode 2
    go(0); ld(16'h0000, 3'd2, 1'b1); exp_st(16'h0000, 1, 1, "R2 bcd zero load");
    go(1); exp_st(16'h0000, 1, 0, "R12 bcd zero transfer");
    go(1); exp_st(16'h9999, 1, 0, "R12 bcd zero first step");
    run(9996);
    go(1); exp_st(16'h0002, 1, 0, "R12 bcd before pulse");
    go(1); exp_st(16'h0001, 0, 0, "R12 bcd pulse at 10000");
    go(1); exp_st(16'h0000, 1, 0, "R9 bcd zero reload");

    go(0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule